// File: doc/BRIEF.md
# UART FIFO Service Interrupt Generator

This block decides when the host must attend to one UART channel's transmitter or receiver. It watches the occupancy of the 64-byte transmit and receive FIFOs, the FIFO-enable control and the programmed trigger thresholds. From these it drives a single active-low interrupt line. The receive side asks for service once enough data has piled up. The transmit side asks for service once room has opened up. When automatic RS-485 direction control is on, the transmit side waits for the whole transmitter to drain, shift register included, before it treats the transmit path as empty.

Each interrupt source has its own two-state machine with the states QUIET and PENDING. A source moves QUIET→PENDING (transition RAISE) on the clock edge where its condition holds. It moves PENDING→QUIET (transition DROP) on the edge where the condition no longer holds. Nothing is latched, so the line follows the current FIFO state with one register of delay. Two status outputs report the free space in the transmit FIFO and the byte count in the receive FIFO. Each threshold comes from a 4-bit select field scaled by 4. A select value of zero picks a fixed default: 32 bytes for transmit and 48 bytes for receive.

Top module: `uart_fifo_irq`

## Requirements
- R1: While reset is low, and at the first clock after it, both source machines are QUIET and irq_n is 1.
- R2: A trigger select of 1 to 15 sets a threshold of select×4 bytes (4 to 60). A select of 0 sets 32 bytes for transmit and 48 bytes for receive.
- R3: With fifo_en=0 and rs485_auto=0, the transmit source is PENDING exactly when tx_level is 0, meaning the holding register is empty.
- R4: With fifo_en=1 and rs485_auto=0, the transmit source is PENDING when tx_level is below the transmit threshold, which includes an empty FIFO. It is QUIET when tx_level is at or above the threshold.
- R5: With rs485_auto=1, a tx_level of 0 counts as empty only while tx_shift_idle=1. With FIFOs off, PENDING requires tx_level=0 and tx_shift_idle=1. With FIFOs on, a level strictly between 0 and the threshold still makes the source PENDING.
- R6: With fifo_en=0, the receive source is PENDING exactly when rx_level is not 0.
- R7: With fifo_en=1, the receive source is PENDING when rx_level is at or above the receive threshold, and QUIET below it.
- R8: tx_space equals 64 minus tx_level, and rx_count equals rx_level, both clamped to the range 0 to 64. They follow their inputs with no clock delay.
- R9: irq_n is 0 exactly when some source is PENDING and its enable (tx_ie or rx_ie) is 1. A disabled source has no effect on irq_n.
- R10: A change of condition reaches irq_n at the next rising clock edge, so the line releases one clock after the condition clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | 1 = FIFO mode, 0 = single holding register mode |
| rs485_auto | input | 1 | Automatic RS-485 direction mode |
| tx_shift_idle | input | 1 | Transmit shift register empty |
| tx_trig_sel | input | 4 | Transmit threshold select |
| rx_trig_sel | input | 4 | Receive threshold select |
| tx_level | input | 7 | Bytes held in the transmit FIFO |
| rx_level | input | 7 | Bytes held in the receive FIFO |
| tx_ie | input | 1 | Transmit interrupt enable |
| rx_ie | input | 1 | Receive interrupt enable |
| irq_n | output | 1 | Active-low interrupt request |
| tx_space | output | 7 | Free transmit FIFO bytes |
| rx_count | output | 7 | Occupied receive FIFO bytes |

## Verification
A source machine stuck in, or wrongly moved to, the PENDING or QUIET state shows up on irq_n one clock after the inputs that should have driven the transition. The bench therefore samples every case half a cycle after the following rising edge. Thresholds are probed on both sides of each boundary: one byte below and exactly at the threshold, plus the default and maximum selects. An off-by-one compare or a wrong scaling then flips irq_n at a single level. In RS-485 mode, a busy shifter with an empty FIFO separates a machine that ignores the shifter from a correct one.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
    typedef enum logic {
        SRC_QUIET   = 1'b0,
        SRC_PENDING = 1'b1
    } src_state_t;

    localparam int NUM_SRC = 2;
    localparam int SRC_TX  = 0;
    localparam int SRC_RX  = 1;
endpackage

// File: rtl/uirq_trig_decode.sv
module uirq_trig_decode #(
    parameter int LVL_W     = 7,
    parameter int SEL_W     = 4,
    parameter int STEP      = 4,
    parameter int DEF_LEVEL = 32
) (
    input  logic [SEL_W-1:0] sel,
    output logic [LVL_W-1:0] level
);
    always_comb begin
        if (sel == '0)
            level = LVL_W'(DEF_LEVEL);
        else
            level = LVL_W'(sel) * LVL_W'(STEP);
    end
endmodule

// File: rtl/uirq_src_fsm.sv
module uirq_src_fsm
    import uirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cond,
    output logic pending
);
    src_state_t state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            SRC_QUIET:   if (cond)  state_nx = SRC_PENDING; // RAISE
            SRC_PENDING: if (!cond) state_nx = SRC_QUIET;   // DROP
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SRC_QUIET;
        else        state <= state_nx;
    end

    always_comb begin
        pending = (state == SRC_PENDING);
    end
endmodule

// File: rtl/uirq_level_report.sv
module uirq_level_report #(
    parameter int DEPTH = 64,
    parameter int LVL_W = 7
) (
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] rx_level,
    output logic [LVL_W-1:0] tx_space,
    output logic [LVL_W-1:0] rx_count
);
    localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);

    always_comb begin
        tx_space = (tx_level >= FULL) ? '0 : FULL - tx_level;
        rx_count = (rx_level >= FULL) ? FULL : rx_level;
    end
endmodule

// File: rtl/uart_fifo_irq.sv
module uart_fifo_irq
    import uirq_pkg::*;
#(
    parameter int DEPTH       = 64,
    parameter int SEL_W       = 4,
    parameter int TRIG_STEP   = 4,
    parameter int TX_DEF_TRIG = 32,
    parameter int RX_DEF_TRIG = 48,
    localparam int LVL_W      = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic             rs485_auto,
    input  logic             tx_shift_idle,
    input  logic [SEL_W-1:0] tx_trig_sel,
    input  logic [SEL_W-1:0] rx_trig_sel,
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] rx_level,
    input  logic             tx_ie,
    input  logic             rx_ie,
    output logic             irq_n,
    output logic [LVL_W-1:0] tx_space,
    output logic [LVL_W-1:0] rx_count
);
    logic [LVL_W-1:0]   tx_trig, rx_trig;
    logic [NUM_SRC-1:0] cond, pend, ie;
    logic               tx_empty_ok;

    uirq_trig_decode #(.LVL_W(LVL_W), .SEL_W(SEL_W), .STEP(TRIG_STEP),
                       .DEF_LEVEL(TX_DEF_TRIG))
        u_tx_trig (.sel(tx_trig_sel), .level(tx_trig));

    uirq_trig_decode #(.LVL_W(LVL_W), .SEL_W(SEL_W), .STEP(TRIG_STEP),
                       .DEF_LEVEL(RX_DEF_TRIG))
        u_rx_trig (.sel(rx_trig_sel), .level(rx_trig));

    always_comb begin
        tx_empty_ok = (tx_level == '0) && (!rs485_auto || tx_shift_idle);
        if (fifo_en)
            cond[SRC_TX] = tx_empty_ok ||
                           ((tx_level != '0) && (tx_level < tx_trig));
        else
            cond[SRC_TX] = tx_empty_ok;
        cond[SRC_RX] = fifo_en ? (rx_level >= rx_trig) : (rx_level != '0);
        ie[SRC_TX]   = tx_ie;
        ie[SRC_RX]   = rx_ie;
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        uirq_src_fsm u_fsm (
            .clk     (clk),
            .rst_n   (rst_n),
            .cond    (cond[g]),
            .pending (pend[g])
        );
    end

    always_comb begin
        irq_n = ~|(pend & ie);
    end

    uirq_level_report #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_lvl (
        .tx_level (tx_level),
        .rx_level (rx_level),
        .tx_space (tx_space),
        .rx_count (rx_count)
    );
endmodule

// File: rtl/uirq_checker.sv
module uirq_checker #(
    parameter int DEPTH = 64,
    parameter int LVL_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fifo_en,
    input logic             rs485_auto,
    input logic             tx_shift_idle,
    input logic [LVL_W-1:0] tx_level,
    input logic [LVL_W-1:0] rx_level,
    input logic             tx_ie,
    input logic             rx_ie,
    input logic             irq_n,
    input logic [LVL_W-1:0] tx_space
);
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> irq_n);

    a_r3_hold_empty: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!fifo_en && !rs485_auto && tx_level == '0) && tx_ie)
        |-> !irq_n);

    a_r5_busy_shifter: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rs485_auto && tx_level == '0 && !tx_shift_idle) && !rx_ie)
        |-> irq_n);

    a_r6_rx_byte: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!fifo_en && rx_level != '0) && rx_ie)
        |-> !irq_n);

    a_r8_space_sum: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(tx_level) <= DEPTH) |-> (int'(tx_space) + int'(tx_level) == DEPTH));

    a_r9_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_ie && !rx_ie) |-> irq_n);
endmodule

bind uart_fifo_irq uirq_checker #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .rs485_auto(rs485_auto),
    .tx_shift_idle(tx_shift_idle), .tx_level(tx_level), .rx_level(rx_level),
    .tx_ie(tx_ie), .rx_ie(rx_ie), .irq_n(irq_n), .tx_space(tx_space)
);

// File: tb/sim_uart_fifo_irq.sv
`timescale 1ns/1ps
module sim_uart_fifo_irq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_en = 1'b0, rs485_auto = 1'b0, tx_shift_idle = 1'b1;
    logic [3:0] tx_trig_sel = 4'd0, rx_trig_sel = 4'd0;
    logic [6:0] tx_level = 7'd0, rx_level = 7'd0;
    logic       tx_ie = 1'b1, rx_ie = 1'b1;
    logic       irq_n;
    logic [6:0] tx_space, rx_count;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    uart_fifo_irq u0 (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .rs485_auto(rs485_auto),
        .tx_shift_idle(tx_shift_idle), .tx_trig_sel(tx_trig_sel),
        .rx_trig_sel(rx_trig_sel), .tx_level(tx_level), .rx_level(rx_level),
        .tx_ie(tx_ie), .rx_ie(rx_ie), .irq_n(irq_n), .tx_space(tx_space),
        .rx_count(rx_count)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // drive at negedge, let one rising edge pass, sample at the next negedge
    task automatic step_irq(input string req, input int exp);
        @(posedge clk);
        @(negedge clk);
        chk(req, irq_n, exp);
    endtask

    task automatic t_reset();
        // inputs would request service, but reset holds the line high
        fifo_en = 0; tx_level = 0; tx_ie = 1; rx_ie = 1;
        repeat (3) @(negedge clk);
        chk("R1 irq_n during reset", irq_n, 1);
        rst_n = 1'b1;
        #0.1;
        chk("R1 irq_n right after release", irq_n, 1);
    endtask

    task automatic t_fifo_off_tx();
        @(negedge clk);
        rx_ie = 0; tx_ie = 1; fifo_en = 0; rs485_auto = 0; tx_level = 0;
        step_irq("R3 holding register empty", 0);
        tx_level = 1;
        step_irq("R3 holding register full", 1);
    endtask

    task automatic t_fifo_on_tx();
        fifo_en = 1; tx_trig_sel = 4'd4;
        tx_level = 15; step_irq("R4 below threshold 16", 0);
        tx_level = 16; step_irq("R4 at threshold 16", 1);
        tx_level = 0;  step_irq("R4 empty fifo", 0);
        tx_trig_sel = 4'd0;
        tx_level = 31; step_irq("R2 tx default 32 below", 0);
        tx_level = 32; step_irq("R2 tx default 32 at", 1);
        tx_trig_sel = 4'd15;
        tx_level = 59; step_irq("R2 select 15 below 60", 0);
        tx_level = 60; step_irq("R2 select 15 at 60", 1);
    endtask

    task automatic t_rs485();
        rs485_auto = 1; fifo_en = 0; tx_level = 0; tx_shift_idle = 0;
        step_irq("R5 fifo off shifter busy", 1);
        tx_shift_idle = 1;
        step_irq("R5 fifo off shifter idle", 0);
        fifo_en = 1; tx_trig_sel = 4'd4; tx_shift_idle = 0;
        step_irq("R5 fifo on empty shifter busy", 1);
        tx_level = 5;
        step_irq("R5 fifo on partial below threshold", 0);
        rs485_auto = 0; tx_level = 16; tx_shift_idle = 1;
        step_irq("R5 leave mode, tx quiet", 1);
    endtask

    task automatic t_rx();
        tx_ie = 0; rx_ie = 1; fifo_en = 0; rx_level = 0;
        step_irq("R6 no data", 1);
        rx_level = 1;
        step_irq("R6 one byte", 0);
        fifo_en = 1; rx_trig_sel = 4'd2;
        rx_level = 7; step_irq("R7 below threshold 8", 1);
        rx_level = 8; step_irq("R7 at threshold 8", 0);
        rx_trig_sel = 4'd0;
        rx_level = 47; step_irq("R2 rx default 48 below", 1);
        rx_level = 48; step_irq("R2 rx default 48 at", 0);
    endtask

    task automatic t_latency();
        rx_trig_sel = 4'd2; rx_level = 8; tx_ie = 0; rx_ie = 1; fifo_en = 1;
        step_irq("R10 setup asserted", 0);
        rx_level = 7;   // a read drops below threshold
        #0.1;
        chk("R10 no change before edge", irq_n, 0);
        step_irq("R10 released one clock later", 1);
    endtask

    task automatic t_enables();
        fifo_en = 0; rx_level = 3; rx_ie = 0; tx_level = 5; tx_ie = 1;
        step_irq("R9 rx pending but disabled", 1);
        rx_ie = 1; #0.1;
        chk("R9 enable takes effect", irq_n, 0);
        rx_ie = 0; tx_ie = 0; tx_level = 0; rx_level = 0;
        step_irq("R9 both disabled", 1);
        tx_ie = 1; #0.1;
        chk("R9 tx enabled pending", irq_n, 0);
    endtask

    task automatic t_counters();
        tx_level = 10; rx_level = 33; #0.1;
        chk("R8 tx space 54", tx_space, 54);
        chk("R8 rx count 33", rx_count, 33);
        tx_level = 64; rx_level = 64; #0.1;
        chk("R8 tx space full", tx_space, 0);
        chk("R8 rx count full", rx_count, 64);
        tx_level = 0; rx_level = 0; #0.1;
        chk("R8 tx space empty", tx_space, 64);
    endtask

    initial begin
        t_reset();
        t_fifo_off_tx();
        t_fifo_on_tx();
        t_rs485();
        t_rx();
        t_latency();
        t_enables();
        t_counters();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule